// File: doc/BRIEF.md
# SYSREF Capture and Local Multiframe Lock

This block watches a periodic SYSREF pulse in the device clock domain and derives a local multiframe clock reference that is phase-locked to it. After reset it waits for a programmable number of device clock cycles. It then runs a repeating control loop. Each loop period opens a capture window at its start and closes it for a programmable pause. A SYSREF rising edge counts only when it lands inside the open window, and the block records where in the window it landed.

When several loop periods in a row each hold a captured edge at the same offset, the block declares lock. It then re-zeroes its multiframe counter on the next captured edge, and from then on emits a one-cycle strobe every multiframe length, for a downstream lane alignment stage. Missing edges drop the lock. Lock lost this way, or a capture window that is not shorter than the SYSREF period, raises a mute request so the data path can be silenced. The busy flag stays high for as long as the block is not locked.

Top module: `sysref_lmfc_lock`

## Requirements
- R1: While reset is asserted and right after it, `mf_strobe_o`, `lock_o` and `mute_o` are 0 and `busy_o` is 1.
- R2: Capture is held off after reset. The control loop starts cfg_delay_i + 1 clock edges after reset release. Each loop period is 2·(cfg_win_hi_i + 1) + cfg_win_lo_i + 1 cycles long, and the window is open for its first 2·(cfg_win_hi_i + 1) cycles.
- R3: SYSREF passes through a two-flop synchronizer and a rising-edge detector. Only the first detected edge inside an open window is recorded, together with its offset in the loop. Edges outside the window are ignored.
- R4: `lock_o` rises on the last cycle edge of the fourth consecutive loop period that holds a recorded edge at the same offset.
- R5: `busy_o` is the inverse of `lock_o`. While locked, a loop period with no recorded edge at the locked offset is a miss. Two consecutive misses clear `lock_o` at the end of the second period.
- R6: `mute_o` rises when lock is dropped by misses, and it clears again when lock is next declared.
- R7: If two SYSREF edges are detected at most 2·(cfg_win_hi_i + 1) cycles apart, a configuration error is latched until reset. `lock_o` is then cleared and is never set, and `mute_o` stays at 1. An interval one cycle longer than the window is not an error.
- R8: Once locked, the first recorded edge at the locked offset zeroes the multiframe counter. `mf_strobe_o` pulses in the following cycle and then every cfg_mf_len_i cycles while locked. It stays at 0 whenever `lock_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, released in step with clk_i |
| sysref_i | input | 1 | Periodic SYSREF pulse, asynchronous to clk_i |
| cfg_delay_i | input | DLY_W (16) | Hold-off before the first loop period, in cycles |
| cfg_win_hi_i | input | WIN_W (8) | Window setting; window length is 2·(value + 1) cycles |
| cfg_win_lo_i | input | WIN_W (8) | Pause setting; closed part of the loop is value + 1 cycles |
| cfg_mf_len_i | input | MF_W (10) | Multiframe length in cycles |
| mf_strobe_o | output | 1 | One-cycle reference multiframe strobe |
| lock_o | output | 1 | Phase lock achieved |
| busy_o | output | 1 | Capture still in progress (not locked) |
| mute_o | output | 1 | Request to silence the data path |

## Verification
The hardest state to reach from the ports is a drop from an established lock into a lasting mute. The same is true of showing that a persistently drifting SYSREF never locks. Both need the SYSREF phase to be placed precisely relative to the internal loop counter. The bench drives SYSREF from a global cycle index with a chosen phase, so that the captured offset is known in advance. It then stops the pulse train, resumes it, and changes its period to 13 and 11 cycles against a 12-cycle loop, while a behavioural model follows every cycle. Separate resets set up a window equal to the SYSREF period, an edge that lands in the closed part of the loop, and a long hold-off.

// File: rtl/sref_lock_pkg.sv
package sref_lock_pkg;

  typedef enum logic {
    PH_HOLD = 1'b0,
    PH_RUN  = 1'b1
  } sref_phase_e;

endpackage

// File: rtl/sref_edge_sync.sv
module sref_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sysref_i,
  output logic edge_o
);

  logic [SYNC_N:0] pipe_q;
  logic [SYNC_N:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[SYNC_N-1:0], sysref_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  // rising edge seen after SYNC_N synchronizer flops
  assign edge_o = pipe_q[SYNC_N-1] & ~pipe_q[SYNC_N];

endmodule

// File: rtl/sref_loop_timer.sv
module sref_loop_timer
  import sref_lock_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int WIN_W = 8,
  localparam int LP_W = WIN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DLY_W-1:0] cfg_delay_i,
  input  logic [WIN_W-1:0] cfg_win_hi_i,
  input  logic [WIN_W-1:0] cfg_win_lo_i,
  output logic             win_open_o,
  output logic             loop_last_o,
  output logic [LP_W-1:0]  pos_o,
  output logic [LP_W-1:0]  win_len_o
);

  sref_phase_e      phase_q, phase_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [LP_W-1:0]  pos_q, pos_d;
  logic [LP_W-1:0]  win_len, loop_len;
  logic             dly_en, pos_en;

  assign win_len  = (LP_W'(cfg_win_hi_i) + LP_W'(1)) << 1;
  assign loop_len = win_len + LP_W'(cfg_win_lo_i) + LP_W'(1);

  assign loop_last_o = (phase_q == PH_RUN) && (pos_q >= loop_len - LP_W'(1));
  assign win_open_o  = (phase_q == PH_RUN) && (pos_q < win_len);
  assign pos_o       = pos_q;
  assign win_len_o   = win_len;

  always_comb begin
    phase_d = phase_q;
    dly_d   = dly_q;
    pos_d   = pos_q;
    dly_en  = 1'b0;
    pos_en  = 1'b0;
    if (phase_q == PH_HOLD) begin
      dly_en = 1'b1;
      if (dly_q == cfg_delay_i) begin
        phase_d = PH_RUN;
        pos_en  = 1'b1;
        pos_d   = '0;
      end else begin
        dly_d = dly_q + DLY_W'(1);
      end
    end else begin
      pos_en = 1'b1;
      pos_d  = loop_last_o ? '0 : pos_q + LP_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HOLD;
      dly_q   <= '0;
      pos_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (dly_en) dly_q <= dly_d;
      if (pos_en) pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/sref_period_check.sv
module sref_period_check #(
  parameter int WIN_W = 8,
  localparam int LP_W = WIN_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic [LP_W-1:0] win_len_i,
  output logic            cfg_err_o
);

  logic [LP_W-1:0] gap_q, gap_d;
  logic            seen_q, seen_d;
  logic            err_q, err_d;
  logic            gap_en;

  always_comb begin
    gap_d  = gap_q;
    seen_d = seen_q;
    err_d  = err_q;
    gap_en = 1'b0;
    if (edge_i) begin
      if (seen_q && (gap_q <= win_len_i)) err_d = 1'b1;
      seen_d = 1'b1;
      gap_en = 1'b1;
      gap_d  = LP_W'(1);
    end else if (gap_q != '1) begin
      gap_en = 1'b1;
      gap_d  = gap_q + LP_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (gap_en) gap_q <= gap_d;
      seen_q <= seen_d;
      err_q  <= err_d;
    end
  end

  assign cfg_err_o = err_q;

endmodule

// File: rtl/sref_lock_fsm.sv
module sref_lock_fsm #(
  parameter int WIN_W  = 8,
  parameter int LOCK_N = 4,
  parameter int MISS_N = 2,
  localparam int LP_W   = WIN_W + 2,
  localparam int STRK_W = $clog2(LOCK_N + 1),
  localparam int MISS_W = $clog2(MISS_N + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic            win_open_i,
  input  logic            loop_last_i,
  input  logic [LP_W-1:0] pos_i,
  input  logic            cfg_err_i,
  output logic            lock_o,
  output logic            lost_o,
  output logic [LP_W-1:0] lock_off_o
);

  logic              got_q, got_d;
  logic [LP_W-1:0]   off_q, off_d;
  logic [LP_W-1:0]   prev_q, prev_d;
  logic [LP_W-1:0]   loff_q, loff_d;
  logic [STRK_W-1:0] strk_q, strk_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              lock_q, lock_d;
  logic              lost_q, lost_d;

  always_comb begin
    got_d  = got_q;
    off_d  = off_q;
    prev_d = prev_q;
    loff_d = loff_q;
    strk_d = strk_q;
    miss_d = miss_q;
    lock_d = lock_q;
    lost_d = lost_q;
    if (loop_last_i) begin
      got_d = 1'b0;
      if (lock_q) begin
        if (got_q && (off_q == loff_q)) begin
          miss_d = '0;
        end else if (miss_q == MISS_W'(MISS_N - 1)) begin
          lock_d = 1'b0;
          lost_d = 1'b1;
          miss_d = '0;
          strk_d = '0;
        end else begin
          miss_d = miss_q + MISS_W'(1);
        end
      end else if (got_q) begin
        prev_d = off_q;
        if ((strk_q != '0) && (off_q == prev_q)) begin
          if (strk_q == STRK_W'(LOCK_N - 1)) begin
            lock_d = 1'b1;
            loff_d = off_q;
            lost_d = 1'b0;
            miss_d = '0;
            strk_d = '0;
          end else begin
            strk_d = strk_q + STRK_W'(1);
          end
        end else begin
          strk_d = STRK_W'(1);
        end
      end else begin
        strk_d = '0;
      end
    end else if (edge_i && win_open_i && !got_q) begin
      got_d = 1'b1;
      off_d = pos_i;
    end
    if (cfg_err_i) begin
      lock_d = 1'b0;
      strk_d = '0;
      miss_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q  <= 1'b0;
      off_q  <= '0;
      prev_q <= '0;
      loff_q <= '0;
      strk_q <= '0;
      miss_q <= '0;
      lock_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      got_q  <= got_d;
      off_q  <= off_d;
      prev_q <= prev_d;
      loff_q <= loff_d;
      strk_q <= strk_d;
      miss_q <= miss_d;
      lock_q <= lock_d;
      lost_q <= lost_d;
    end
  end

  assign lock_o     = lock_q;
  assign lost_o     = lost_q;
  assign lock_off_o = loff_q;

endmodule

// File: rtl/sref_lmfc_gen.sv
module sref_lmfc_gen #(
  parameter int WIN_W = 8,
  parameter int MF_W  = 10,
  localparam int LP_W = WIN_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lock_i,
  input  logic            edge_i,
  input  logic            win_open_i,
  input  logic [LP_W-1:0] pos_i,
  input  logic [LP_W-1:0] lock_off_i,
  input  logic [MF_W-1:0] cfg_mf_len_i,
  output logic            strobe_o
);

  logic            al_q, al_d;
  logic [MF_W-1:0] mf_q, mf_d;
  logic            mf_en;

  always_comb begin
    al_d  = al_q;
    mf_d  = mf_q;
    mf_en = 1'b0;
    if (!lock_i) begin
      al_d  = 1'b0;
      mf_en = 1'b1;
      mf_d  = '0;
    end else if (!al_q) begin
      if (edge_i && win_open_i && (pos_i == lock_off_i)) begin
        al_d  = 1'b1;
        mf_en = 1'b1;
        mf_d  = '0;
      end
    end else begin
      mf_en = 1'b1;
      mf_d  = (mf_q >= cfg_mf_len_i - MF_W'(1)) ? '0 : mf_q + MF_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al_q <= 1'b0;
      mf_q <= '0;
    end else begin
      al_q <= al_d;
      if (mf_en) mf_q <= mf_d;
    end
  end

  assign strobe_o = lock_i & al_q & (mf_q == '0);

endmodule

// File: rtl/sysref_lmfc_lock.sv
module sysref_lmfc_lock #(
  parameter int DLY_W  = 16,
  parameter int WIN_W  = 8,
  parameter int MF_W   = 10,
  parameter int LOCK_N = 4,
  parameter int MISS_N = 2,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sysref_i,
  input  logic [DLY_W-1:0] cfg_delay_i,
  input  logic [WIN_W-1:0] cfg_win_hi_i,
  input  logic [WIN_W-1:0] cfg_win_lo_i,
  input  logic [MF_W-1:0]  cfg_mf_len_i,
  output logic             mf_strobe_o,
  output logic             lock_o,
  output logic             busy_o,
  output logic             mute_o
);

  localparam int LP_W = WIN_W + 2;

  logic            edge_w;
  logic            win_open_w;
  logic            loop_last_w;
  logic [LP_W-1:0] pos_w;
  logic [LP_W-1:0] win_len_w;
  logic            cfg_err_w;
  logic            lost_w;
  logic            lock_w;
  logic [LP_W-1:0] lock_off_w;

  sref_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sysref_i (sysref_i),
    .edge_o   (edge_w)
  );

  sref_loop_timer #(.DLY_W(DLY_W), .WIN_W(WIN_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_delay_i  (cfg_delay_i),
    .cfg_win_hi_i (cfg_win_hi_i),
    .cfg_win_lo_i (cfg_win_lo_i),
    .win_open_o   (win_open_w),
    .loop_last_o  (loop_last_w),
    .pos_o        (pos_w),
    .win_len_o    (win_len_w)
  );

  sref_period_check #(.WIN_W(WIN_W)) u_pchk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_w),
    .win_len_i (win_len_w),
    .cfg_err_o (cfg_err_w)
  );

  sref_lock_fsm #(.WIN_W(WIN_W), .LOCK_N(LOCK_N), .MISS_N(MISS_N)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (edge_w),
    .win_open_i  (win_open_w),
    .loop_last_i (loop_last_w),
    .pos_i       (pos_w),
    .cfg_err_i   (cfg_err_w),
    .lock_o      (lock_w),
    .lost_o      (lost_w),
    .lock_off_o  (lock_off_w)
  );

  sref_lmfc_gen #(.WIN_W(WIN_W), .MF_W(MF_W)) u_lmfc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_i       (lock_w),
    .edge_i       (edge_w),
    .win_open_i   (win_open_w),
    .pos_i        (pos_w),
    .lock_off_i   (lock_off_w),
    .cfg_mf_len_i (cfg_mf_len_i),
    .strobe_o     (mf_strobe_o)
  );

  assign lock_o = lock_w;
  assign busy_o = ~lock_w;
  assign mute_o = cfg_err_w | lost_w;

endmodule

// File: rtl/sref_lock_chk.sv
module sref_lock_chk #(
  parameter int MF_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [MF_W-1:0] cfg_mf_len_i,
  input logic            mf_strobe_o,
  input logic            lock_o,
  input logic            busy_o,
  input logic            mute_o,
  input logic            loop_last_w,
  input logic            cfg_err_w
);

  a_r4_lock_at_loop_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(loop_last_w));

  a_r5_busy_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(loop_last_w) || $past(cfg_err_w)));

  a_r6_drop_mutes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lock_o) && !$past(cfg_err_w)) |-> mute_o);

  a_r7_err_kills_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_w |=> !lock_o);

  a_r8_strobe_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mf_strobe_o && (cfg_mf_len_i > MF_W'(1))) |=> !mf_strobe_o);

endmodule

bind sysref_lmfc_lock sref_lock_chk #(.MF_W(MF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_mf_len_i (cfg_mf_len_i),
  .mf_strobe_o  (mf_strobe_o),
  .lock_o       (lock_o),
  .busy_o       (busy_o),
  .mute_o       (mute_o),
  .loop_last_w  (loop_last_w),
  .cfg_err_w    (cfg_err_w)
);

// File: tb/tb_sysref_lmfc_lock.sv
`timescale 1ns/1ps
module tb_sysref_lmfc_lock;

  localparam int DLY_W = 16;
  localparam int WIN_W = 8;
  localparam int MF_W  = 10;
  localparam int CYC   = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sysref = 1'b0;
  logic [DLY_W-1:0] cfg_delay = 16'd5;
  logic [WIN_W-1:0] cfg_hi = 8'd4;
  logic [WIN_W-1:0] cfg_lo = 8'd1;
  logic [MF_W-1:0]  cfg_mf = 10'd6;
  logic             mf_strobe, lock, busy, mute;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // sysref generator controls
  bit sr_en  = 1'b0;
  int sr_per = 12;
  int sr_ph  = 5;
  int gi     = 0;

  always #(CYC/2) clk = ~clk;

  sysref_lmfc_lock dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sysref_i     (sysref),
    .cfg_delay_i  (cfg_delay),
    .cfg_win_hi_i (cfg_hi),
    .cfg_win_lo_i (cfg_lo),
    .cfg_mf_len_i (cfg_mf),
    .mf_strobe_o  (mf_strobe),
    .lock_o       (lock),
    .busy_o       (busy),
    .mute_o       (mute)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      gi     <= 0;
      sysref <= 1'b0;
    end else begin
      sysref <= sr_en && (((gi % sr_per) == sr_ph) || ((gi % sr_per) == sr_ph + 1));
      gi     <= gi + 1;
    end
  end

  // ---------------- behavioural reference model ----------------
  int hist[$];
  bit m_run, m_got, m_lock, m_lost, m_err, m_seen, m_al;
  int m_dly, m_pos, m_off, m_prev, m_loff, m_strk, m_miss, m_gap, m_mf;
  bit t_e, t_open, t_last;
  int t_wl, t_ll;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {0, 0, 0};
      m_run = 0; m_got = 0; m_lock = 0; m_lost = 0; m_err = 0; m_seen = 0; m_al = 0;
      m_dly = 0; m_pos = 0; m_off = 0; m_prev = 0; m_loff = 0; m_strk = 0; m_miss = 0;
      m_gap = 0; m_mf = 0;
    end else begin
      t_wl   = 2 * (int'(cfg_hi) + 1);
      t_ll   = t_wl + int'(cfg_lo) + 1;
      t_e    = (hist[1] != 0) && (hist[2] == 0);
      t_open = m_run && (m_pos < t_wl);
      t_last = m_run && (m_pos >= t_ll - 1);
      // multiframe generator, uses lock as it stood before this edge
      if (!m_lock) begin m_al = 0; m_mf = 0; end
      else if (!m_al) begin
        if (t_e && t_open && m_pos == m_loff) begin m_al = 1; m_mf = 0; end
      end else m_mf = (m_mf >= int'(cfg_mf) - 1) ? 0 : m_mf + 1;
      // lock tracking
      if (t_last) begin
        if (m_lock) begin
          if (m_got && m_off == m_loff) m_miss = 0;
          else if (m_miss == 1) begin m_lock = 0; m_lost = 1; m_miss = 0; m_strk = 0; end
          else m_miss = m_miss + 1;
        end else if (m_got) begin
          if (m_strk != 0 && m_off == m_prev) begin
            if (m_strk == 3) begin m_lock = 1; m_loff = m_off; m_lost = 0; m_miss = 0; m_strk = 0; end
            else m_strk = m_strk + 1;
          end else m_strk = 1;
          m_prev = m_off;
        end else m_strk = 0;
        m_got = 0;
      end else if (t_e && t_open && !m_got) begin
        m_got = 1; m_off = m_pos;
      end
      if (m_err) begin m_lock = 0; m_strk = 0; m_miss = 0; end
      // sysref interval check
      if (t_e) begin
        if (m_seen && m_gap <= t_wl) m_err = 1;
        m_seen = 1; m_gap = 1;
      end else if (m_gap < 1023) m_gap = m_gap + 1;
      // loop timer
      if (!m_run) begin
        if (m_dly == int'(cfg_delay)) begin m_run = 1; m_pos = 0; end
        else m_dly = m_dly + 1;
      end else m_pos = t_last ? 0 : m_pos + 1;
      // synchronizer history
      hist.push_front(int'(sysref));
      hist.pop_back();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(mf_strobe == (m_lock && m_al && m_mf == 0), "R8 strobe vs model",
          int'(mf_strobe), int'(m_lock && m_al && m_mf == 0));
      chk(lock == m_lock, "R4 lock vs model", int'(lock), int'(m_lock));
      chk(busy == !m_lock, "R5 busy vs model", int'(busy), int'(!m_lock));
      chk(mute == (m_err || m_lost), "R6 mute vs model", int'(mute), int'(m_err || m_lost));
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    sr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(lock == 0 && busy == 1 && mute == 0 && mf_strobe == 0, "R1 reset state",
        {mf_strobe, lock, busy, mute}, 4'b0010);
    #1 rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  int strobes;

  initial begin
    // scenario: steady SYSREF, edge at offset 2 of a 12-cycle loop
    cfg_delay = 16'd5; cfg_hi = 8'd4; cfg_lo = 8'd1; cfg_mf = 10'd6;
    sr_per = 12; sr_ph = 5;
    do_reset();
    sr_en = 1'b1;
    run(240);
    chk(lock == 1, "R4 locked on steady sysref", int'(lock), 1);
    chk(busy == 0 && mute == 0, "R5 busy/mute low while locked", int'({busy, mute}), 0);
    strobes = 0;
    repeat (60) begin
      @(negedge clk);
      if (mf_strobe) strobes++;
    end
    chk(strobes == 10, "R8 strobe count over 60 cycles", strobes, 10);
    // stop SYSREF: two misses drop the lock
    sr_en = 1'b0;
    run(60);
    chk(lock == 0 && busy == 1, "R5 lock dropped after misses", int'({lock, busy}), 1);
    chk(mute == 1, "R6 mute after lock loss", int'(mute), 1);
    chk(mf_strobe == 0, "R8 no strobe while unlocked", int'(mf_strobe), 0);
    // resume: relock clears mute
    sr_en = 1'b1;
    run(240);
    chk(lock == 1 && mute == 0, "R6 relock clears mute", int'({lock, mute}), 2);
    // drifting SYSREF period never holds lock
    sr_per = 13;
    run(240);
    chk(lock == 0, "R4 drifting offset does not lock", int'(lock), 0);

    // scenario: edge lands in the closed part of the loop
    sr_per = 12; sr_ph = 1;
    do_reset();
    sr_en = 1'b1;
    run(240);
    chk(lock == 0 && mute == 0, "R3 edges outside window ignored", int'({lock, mute}), 0);

    // scenario: long hold-off
    cfg_delay = 16'd197; sr_ph = 5;
    do_reset();
    sr_en = 1'b1;
    run(144);
    chk(lock == 0, "R2 no lock during hold-off", int'(lock), 0);
    run(240);
    chk(lock == 1, "R2 lock after hold-off", int'(lock), 1);

    // scenario: window equal to SYSREF period
    cfg_delay = 16'd5; cfg_hi = 8'd5; cfg_lo = 8'd0; sr_per = 12;
    do_reset();
    sr_en = 1'b1;
    run(240);
    chk(lock == 0 && busy == 1, "R7 config error keeps unlocked", int'({lock, busy}), 1);
    chk(mute == 1, "R7 config error raises mute", int'(mute), 1);

    // scenario: interval one cycle longer than window, no error
    cfg_hi = 8'd4; cfg_lo = 8'd1; sr_per = 11;
    do_reset();
    sr_en = 1'b1;
    run(240);
    chk(mute == 0, "R7 interval window+1 is not an error", int'(mute), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CYC * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule